// File: doc/BRIEF.md
# SPI Command Decoder and Chip-Select Router

This block is a small SPI slave on a shared control bus, reached through its own chip select. A host sends it commands of exactly two bytes, an opcode and then an argument. The commands set a selector register that picks which downstream device receives a separate common-stream chip select. They also set two ADC control lines and start or reset two FPGA configuration loaders. During the argument byte the block returns one reply byte. That byte holds a main-board version byte, the logic version, or the status bits of the first loader.

The block runs on a fast system clock. SCK, chip select, MOSI and the loader status bits each pass through a two-flop synchronizer before the logic uses them. SPI mode 0 is used: data moves MSB first, the slave samples MOSI on the rising SCK edge and changes MISO after the falling edge. Several commands may follow one another inside one chip-select frame. The block has no data stream of its own, so every pin is a plain control or status line and there is no valid/ready handshake and no back-pressure.

Top module: `spi_cmd_router`

## Requirements
- R1: Bytes are 8 bits, MSB first. MOSI is sampled on the rising SCK edge while `spi_cs_n` is low. Bytes alternate opcode, argument, opcode, argument, and so on within a frame.
- R2: Opcode 0x01 stores its argument as the selector when the argument is 0 to 7. A larger argument is ignored. After reset the selector is 7.
- R3: For selector values 0 to 6, `tgt_cs_n[sel]` follows `strm_cs_n` and every other line is 1. For selector 7 all seven lines are 1.
- R4: Opcode 0x05 copies argument bit 1 to `adc_rst` and argument bit 0 to `adc_ctl`. Both are 0 after reset.
- R5: The reply to opcode 0x06 is `BOARD_VER[7:0]`, and the reply to opcode 0x07 is `BOARD_VER[15:8]`.
- R6: The reply to opcode 0x08 is `LOGIC_VER` in the low nibble, with the upper nibble 0.
- R7: Opcode 0x0B with argument 0 clears `ldr_a_run`, and with argument 1 sets it. Opcode 0x0D does the same for `ldr_b_run`. Any other argument is ignored. Both are 0 after reset.
- R8: The reply to opcode 0x0B is the synchronized `ldr_a_stat` value in its low bits, with the upper bits 0.
- R9: The byte shifted out during every opcode byte is 0x00. An unknown opcode replies 0x00 and changes no output.
- R10: If `spi_cs_n` rises before a command's 16th bit, the partial command has no effect. The next frame starts again with an opcode byte.
- R11: Back-to-back commands in one frame each take effect and each return their own reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | Chip select of this block, active low |
| spi_mosi | input | 1 | Command data from the host |
| spi_miso | output | 1 | Reply data to the host |
| strm_cs_n | input | 1 | Common-stream chip select to be routed |
| tgt_cs_n | output | 7 | Routed chip selects, one per downstream target |
| ldr_a_stat | input | 4 | Status bits of the first loader (asynchronous) |
| adc_rst | output | 1 | ADC reset control |
| adc_ctl | output | 1 | ADC general control |
| ldr_a_run | output | 1 | First loader: 0 held in reset, 1 loading |
| ldr_b_run | output | 1 | Second loader: 0 held in reset, 1 loading |

## Verification
When two commands share a frame, two things happen in the same system-clock cycle: the write of the first command, and the start of the next opcode byte, where the reply register must go back to 0x00 instead of keeping the old reply. The bench provokes this with frames that pair a selector write with a version read, and an ADC write with a version read. A behavioural model predicts every MISO bit of such a frame and the outputs afterwards. A second overlap is a loader status change while a status read is in flight. Status is changed only between frames, so the synchronized value the reply carries is known.

// File: rtl/cmdrt_pkg.sv
package cmdrt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] OPC_SEL    = 8'h01;
  localparam logic [7:0] OPC_ADC    = 8'h05;
  localparam logic [7:0] OPC_VER_LO = 8'h06;
  localparam logic [7:0] OPC_VER_HI = 8'h07;
  localparam logic [7:0] OPC_LOGIC  = 8'h08;
  localparam logic [7:0] OPC_LDR_A  = 8'h0B;
  localparam logic [7:0] OPC_LDR_B  = 8'h0D;
endpackage

// File: rtl/cmdrt_sync.sv
module cmdrt_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cmdrt_spi_fe.sv
module cmdrt_spi_fe
  import cmdrt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] reply,
  output logic              miso,
  output logic              idle,
  output logic              byte_vld,
  output logic              byte_first,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [2:0] pins_q;
  logic cs_q, sck_q, mosi_q, sck_d, rise, fall, second;
  logic [CNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;

  cmdrt_sync #(.W(3), .RST_VAL(3'b100)) u_pins (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, mosi}), .q(pins_q)
  );

  assign cs_q   = pins_q[2];
  assign sck_q  = pins_q[1];
  assign mosi_q = pins_q[0];
  assign rise   = sck_q & ~sck_d & ~cs_q;
  assign fall   = ~sck_q & sck_d & ~cs_q;
  assign miso   = tx_sh[BYTE_W-1];
  assign idle   = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d      <= 1'b0;
      bit_cnt    <= '0;
      second     <= 1'b0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      byte_vld   <= 1'b0;
      byte_first <= 1'b0;
      byte_data  <= '0;
    end else begin
      sck_d    <= sck_q;
      byte_vld <= 1'b0;
      if (cs_q) begin
        bit_cnt <= '0;
        second  <= 1'b0;
        tx_sh   <= '0;
      end else if (rise) begin
        rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_q};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          byte_vld   <= 1'b1;
          byte_first <= ~second;
          byte_data  <= {rx_sh[BYTE_W-2:0], mosi_q};
          second     <= ~second;
        end
      end else if (fall) begin
        if (bit_cnt == '0) tx_sh <= second ? reply : '0;
        else               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/cmdrt_decoder.sv
module cmdrt_decoder
  import cmdrt_pkg::*;
#(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned STAT_W    = 4,
  parameter logic [15:0] BOARD_VER = 16'h2A51,
  parameter logic [3:0]  LOGIC_VER = 4'h9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              byte_first,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [STAT_W-1:0] stat_raw,
  output logic [SEL_W-1:0]  sel,
  output logic              adc_rst,
  output logic              adc_ctl,
  output logic              run_a,
  output logic              run_b,
  output logic [BYTE_W-1:0] op,
  output logic [BYTE_W-1:0] reply
);
  localparam logic [SEL_W-1:0] SEL_OFF = {SEL_W{1'b1}};

  logic [STAT_W-1:0] stat_s;
  logic arg_fits;

  cmdrt_sync #(.W(STAT_W), .RST_VAL('0)) u_stat (
    .clk(clk), .rst_n(rst_n), .d(stat_raw), .q(stat_s)
  );

  assign arg_fits = (byte_data[BYTE_W-1:SEL_W] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op      <= '0;
      sel     <= SEL_OFF;
      adc_rst <= 1'b0;
      adc_ctl <= 1'b0;
      run_a   <= 1'b0;
      run_b   <= 1'b0;
    end else if (byte_vld) begin
      if (byte_first) begin
        op <= byte_data;
      end else begin
        case (op)
          OPC_SEL: if (arg_fits) sel <= byte_data[SEL_W-1:0];
          OPC_ADC: begin
            adc_rst <= byte_data[1];
            adc_ctl <= byte_data[0];
          end
          OPC_LDR_A: begin
            if (byte_data == 8'h00) run_a <= 1'b0;
            else if (byte_data == 8'h01) run_a <= 1'b1;
          end
          OPC_LDR_B: begin
            if (byte_data == 8'h00) run_b <= 1'b0;
            else if (byte_data == 8'h01) run_b <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (op)
      OPC_VER_LO: reply = BOARD_VER[7:0];
      OPC_VER_HI: reply = BOARD_VER[15:8];
      OPC_LOGIC:  reply = {4'h0, LOGIC_VER};
      OPC_LDR_A:  reply = {{(BYTE_W-STAT_W){1'b0}}, stat_s};
      default:    reply = '0;
    endcase
  end
endmodule

// File: rtl/cmdrt_router.sv
module cmdrt_router #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned NLINE = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             strm_cs_n,
  output logic [NLINE-1:0] tgt_cs_n
);
  for (genvar i = 0; i < NLINE; i++) begin : g_line
    assign tgt_cs_n[i] = (sel == SEL_W'(i)) ? strm_cs_n : 1'b1;
  end
endmodule

// File: rtl/spi_cmd_router.sv
module spi_cmd_router
  import cmdrt_pkg::*;
#(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned STAT_W    = 4,
  parameter logic [15:0] BOARD_VER = 16'h2A51,
  parameter logic [3:0]  LOGIC_VER = 4'h9,
  localparam int unsigned NLINE    = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              strm_cs_n,
  output logic [NLINE-1:0]  tgt_cs_n,
  input  logic [STAT_W-1:0] ldr_a_stat,
  output logic              adc_rst,
  output logic              adc_ctl,
  output logic              ldr_a_run,
  output logic              ldr_b_run
);
  logic              fe_idle, byte_vld, byte_first;
  logic [BYTE_W-1:0] byte_data, reply, cur_op;
  logic [SEL_W-1:0]  sel;

  cmdrt_spi_fe u_fe (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .reply(reply), .miso(spi_miso), .idle(fe_idle), .byte_vld(byte_vld),
    .byte_first(byte_first), .byte_data(byte_data)
  );

  cmdrt_decoder #(
    .SEL_W(SEL_W), .STAT_W(STAT_W), .BOARD_VER(BOARD_VER), .LOGIC_VER(LOGIC_VER)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_first(byte_first),
    .byte_data(byte_data), .stat_raw(ldr_a_stat), .sel(sel), .adc_rst(adc_rst),
    .adc_ctl(adc_ctl), .run_a(ldr_a_run), .run_b(ldr_b_run), .op(cur_op),
    .reply(reply)
  );

  cmdrt_router #(.SEL_W(SEL_W)) u_rt (
    .sel(sel), .strm_cs_n(strm_cs_n), .tgt_cs_n(tgt_cs_n)
  );
endmodule

// File: rtl/cmdrt_checker.sv
module cmdrt_checker
  import cmdrt_pkg::*;
#(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned NLINE = (1 << SEL_W) - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strm_cs_n,
  input logic [NLINE-1:0]  tgt_cs_n,
  input logic              miso,
  input logic              fe_idle,
  input logic              byte_vld,
  input logic [BYTE_W-1:0] op,
  input logic [SEL_W-1:0]  sel,
  input logic              adc_rst,
  input logic              adc_ctl,
  input logic              run_a,
  input logic              run_b
);
  p_single_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~tgt_cs_n));

  p_idle_lines_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strm_cs_n |-> (&tgt_cs_n));

  p_miso_low_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fe_idle |=> !miso);

  p_no_write_without_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable({sel, adc_rst, adc_ctl, run_a, run_b}));

  p_run_a_by_opcode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_a) |-> (op == OPC_LDR_A));

  p_run_b_by_opcode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_b) |-> (op == OPC_LDR_B));
endmodule

bind spi_cmd_router cmdrt_checker #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strm_cs_n(strm_cs_n), .tgt_cs_n(tgt_cs_n),
  .miso(spi_miso), .fe_idle(fe_idle), .byte_vld(byte_vld), .op(cur_op),
  .sel(sel), .adc_rst(adc_rst), .adc_ctl(adc_ctl), .run_a(ldr_a_run),
  .run_b(ldr_b_run)
);

// File: tb/spi_cmd_router_test.sv
module spi_cmd_router_test;
  localparam int H = 6;
  localparam logic [15:0] BV = 16'h2A51;
  localparam logic [3:0]  LV = 4'h9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, strm_cs_n = 1'b1;
  logic [3:0] ldr_a_stat = 4'h0;
  logic spi_miso, adc_rst, adc_ctl, ldr_a_run, ldr_b_run;
  logic [6:0] tgt_cs_n;

  int checks = 0, errors = 0;
  bit settled = 0;
  int m_sel = 7;
  logic m_adc_rst = 0, m_adc_ctl = 0, m_ra = 0, m_rb = 0;

  always #2.5 clk = ~clk;

  spi_cmd_router uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .strm_cs_n(strm_cs_n),
    .tgt_cs_n(tgt_cs_n), .ldr_a_stat(ldr_a_stat), .adc_rst(adc_rst),
    .adc_ctl(adc_ctl), .ldr_a_run(ldr_a_run), .ldr_b_run(ldr_b_run)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] exp_lines();
    logic [6:0] v = '1;
    for (int i = 0; i < 7; i++) if (m_sel == i) v[i] = strm_cs_n;
    return v;
  endfunction

  function automatic logic [7:0] m_reply(input logic [7:0] op);
    case (op)
      8'h06: return BV[7:0];
      8'h07: return BV[15:8];
      8'h08: return {4'h0, LV};
      8'h0B: return {4'h0, ldr_a_stat};
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_exec(input logic [7:0] op, input logic [7:0] arg);
    case (op)
      8'h01: if (arg <= 8'd7) m_sel = int'(arg);
      8'h05: begin m_adc_rst = arg[1]; m_adc_ctl = arg[0]; end
      8'h0B: if (arg == 0) m_ra = 0; else if (arg == 1) m_ra = 1;
      8'h0D: if (arg == 0) m_rb = 0; else if (arg == 1) m_rb = 1;
      default: ;
    endcase
  endtask

  // per-clock comparison of the block's outputs against the model (R2 R3 R4 R7)
  always @(negedge clk) if (settled) begin
    chk("R3 routed lines", {25'd0, tgt_cs_n}, {25'd0, exp_lines()});
    chk("R4 adc lines", {30'd0, adc_rst, adc_ctl}, {30'd0, m_adc_rst, m_adc_ctl});
    chk("R7 loader run", {30'd0, ldr_a_run, ldr_b_run}, {30'd0, m_ra, m_rb});
  end

  task automatic bit_io(input logic b, output logic r);
    spi_mosi = b;
    repeat (H) @(negedge clk);
    r = spi_miso;
    spi_sck = 1'b1;
    repeat (H) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic byte_io(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bit_io(t[i], r[i]);
  endtask

  task automatic open_frame();
    settled = 0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic close_frame();
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic cmds(input int n, input logic [7:0] o0, input logic [7:0] a0,
                      input logic [7:0] o1, input logic [7:0] a1, input string req);
    logic [7:0] r;
    logic [7:0] ops [2], args [2];
    ops[0] = o0; args[0] = a0; ops[1] = o1; args[1] = a1;
    open_frame();
    for (int k = 0; k < n; k++) begin
      byte_io(ops[k], r);
      chk({"R9 opcode-byte reply ", req}, {24'd0, r}, 32'h0);
      byte_io(args[k], r);
      chk({"R1 reply ", req}, {24'd0, r}, {24'd0, m_reply(ops[k])});
    end
    close_frame();
    for (int k = 0; k < n; k++) m_exec(ops[k], args[k]);
    settled = 1;
    @(negedge clk);
  endtask

  task automatic partial(input logic [15:0] bits, input int nbits);
    logic r;
    open_frame();
    for (int i = 15; i > 15 - nbits; i--) bit_io(bits[i], r);
    close_frame();
    settled = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    strm_cs_n = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state: selector off, all outputs low (R2 R4 R7)
    chk("R2 reset all lines high", {25'd0, tgt_cs_n}, {25'd0, 7'h7F});
    chk("R4 reset adc", {30'd0, adc_rst, adc_ctl}, 32'd0);
    chk("R7 reset loaders", {30'd0, ldr_a_run, ldr_b_run}, 32'd0);
    chk("R9 reset miso", {31'd0, spi_miso}, 32'd0);
    settled = 1;

    cmds(1, 8'h01, 8'h03, 0, 0, "R2 sel3");
    chk("R3 line3 follows stream", {25'd0, tgt_cs_n}, {25'd0, 7'h77});
    strm_cs_n = 1'b1; repeat (3) @(negedge clk);
    chk("R3 stream high", {25'd0, tgt_cs_n}, {25'd0, 7'h7F});
    strm_cs_n = 1'b0;
    cmds(1, 8'h01, 8'h00, 0, 0, "R2 sel0");
    cmds(1, 8'h01, 8'h09, 0, 0, "R2 out-of-range ignored");
    chk("R2 still line0", {25'd0, tgt_cs_n}, {25'd0, 7'h7E});
    cmds(1, 8'h01, 8'h07, 0, 0, "R3 off target");
    chk("R3 off all high", {25'd0, tgt_cs_n}, {25'd0, 7'h7F});
    cmds(1, 8'h01, 8'h05, 0, 0, "R2 sel5");

    cmds(1, 8'h05, 8'h02, 0, 0, "R4 rst");
    cmds(1, 8'h05, 8'h01, 0, 0, "R4 ctl");
    cmds(1, 8'h05, 8'h03, 0, 0, "R4 both");
    chk("R4 both high", {30'd0, adc_rst, adc_ctl}, 32'd3);
    cmds(1, 8'h05, 8'hFC, 0, 0, "R4 clear");

    cmds(1, 8'h06, 8'h00, 0, 0, "R5 low version");
    cmds(1, 8'h07, 8'h00, 0, 0, "R5 high version");
    cmds(1, 8'h08, 8'h00, 0, 0, "R6 logic version");

    ldr_a_stat = 4'hA; repeat (4) @(negedge clk);
    cmds(1, 8'h0B, 8'h00, 0, 0, "R8 status A");
    cmds(1, 8'h0B, 8'h01, 0, 0, "R7 start A");
    chk("R7 run_a set", {31'd0, ldr_a_run}, 32'd1);
    ldr_a_stat = 4'h5; repeat (4) @(negedge clk);
    cmds(1, 8'h0B, 8'h07, 0, 0, "R8 status 5 arg ignored");
    cmds(1, 8'h0D, 8'h01, 0, 0, "R7 start B");
    cmds(1, 8'h0D, 8'h00, 0, 0, "R7 reset B");
    cmds(1, 8'h0D, 8'h01, 0, 0, "R7 start B again");
    cmds(1, 8'h0B, 8'h00, 0, 0, "R7 reset A");

    cmds(1, 8'h3C, 8'hFF, 0, 0, "R9 unknown opcode");

    // R10: aborts after opcode plus four argument bits, and inside the opcode
    partial({8'h01, 8'h02}, 12);
    chk("R10 abort keeps line5", {25'd0, tgt_cs_n}, {25'd0, 7'h5F});
    partial({8'h05, 8'h03}, 5);
    chk("R10 abort keeps adc", {30'd0, adc_rst, adc_ctl}, 32'd0);
    cmds(1, 8'h01, 8'h02, 0, 0, "R10 fresh after abort");
    chk("R10 line2", {25'd0, tgt_cs_n}, {25'd0, 7'h7B});

    // R11: two commands in one frame
    cmds(2, 8'h01, 8'h04, 8'h08, 8'h00, "R11 sel+logic");
    chk("R11 line4", {25'd0, tgt_cs_n}, {25'd0, 7'h6F});
    cmds(2, 8'h05, 8'h03, 8'h06, 8'h00, "R11 adc+version");
    chk("R11 adc", {30'd0, adc_rst, adc_ctl}, 32'd3);

    settled = 0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule